// File: doc/BRIEF.md
# Asynchronous DRAM Access and Refresh Sequencer

This block sits between a synchronous host and an asynchronous page-mode DRAM with a narrow data bus. The host issues single-word reads and writes on a valid/ready interface. The block splits each host address into a row part and a column part. It presents both parts on one shared set of address pins. It then drives the row strobe, column strobe, write enable and output enable in the order the memory expects. Every pulse width and gap is an elaboration-time count of clock cycles.

The sequencer also keeps the memory alive. After reset it holds off for a long settling pause, then runs a series of row-strobe-only dummy cycles. Only after those does it accept host traffic. After that it counts a fixed refresh interval. Each time the interval expires it runs a refresh cycle in which the column strobe falls first. A refresh takes precedence over a waiting host request, but an access that has already started always runs to completion. The data bus is modelled as separate in, out and drive-enable signals.

Top module: `dramc_top`

## Requirements
- R1: While reset is held, the row strobe, column strobe, write enable and output enable pins are all high (inactive, active-low encoding). The data drive enable, `req_ready` and `rsp_valid` are all low.
- R2: After reset releases, the row strobe stays high for at least INIT_WAIT cycles. The block then performs INIT_CYCLES cycles in which the row strobe falls while the column strobe is high. `req_ready` stays low until all of them have finished.
- R3: For an access, the address pins carry `req_addr[ROW_W+COL_W-1:COL_W]` when the row strobe falls. They carry `req_addr[COL_W-1:0]`, zero-extended to the pin width, when the column strobe falls.
- R4: In an access, the column strobe falls exactly T_RCD cycles after the row strobe falls. In every cycle of any kind, the row strobe stays low for at least T_RAS cycles.
- R5: Between two cycles, the row strobe stays high for at least max(T_RP, T_CP) cycles. The column strobe never falls before it has been high for T_CP cycles.
- R6: A read keeps the write enable high and holds the output enable low for as long as the column strobe is low. The read data is sampled in the last cycle of the column strobe. `rsp_valid` pulses for one cycle, in the first cycle after the row strobe rises, carrying that data on `rsp_rdata`.
- R7: A write drives `dram_dq_out` with the request data and raises `dram_dq_oe` from the row-strobe fall onward. It holds the write enable low exactly while the column strobe is low, and keeps the output enable high.
- R8: A refresh lowers the column strobe exactly T_CSR cycles before the row strobe falls. During the whole cycle, the write enable and output enable stay high and `dram_dq_oe` stays low.
- R9: With no host traffic, one refresh cycle starts every REF_INTERVAL cycles.
- R10: `req_ready` is high only while both strobes are high and no refresh is pending. A pending refresh waits for a running access to finish and is never interleaved into it, so all host data stays intact under continuous traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Host word address, row bits on top |
| req_wdata | input | DQ_W | Write data |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | DQ_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address pins |
| dram_dq_out | output | DQ_W | Data driven to the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DQ_W | Data returned by the memory |

## Verification
A sequencer stuck in the wrong state, or a cycle timer loaded with the wrong count, shows up on the strobe pins within one access: a shortened low phase, a missing gap or a wrong strobe-to-strobe delay. The bench measures each of these at the falling and rising strobe edges. A wrong address split or a mistimed data sample does not show up on the strobes. It corrupts the word the memory model stores or returns, so it appears at the next read-back of that address, or at once on the pins where the column is latched. A broken refresh scheduler shows up either as a gap in the refresh count over an idle window, or as a refresh whose column strobe leads by the wrong count or that drives data.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

   typedef enum logic [3:0] {
      S_WAIT,    // power-up pause
      S_IRAS,    // dummy row-strobe pulse
      S_IPRE,    // gap after dummy pulse
      S_IDLE,
      S_ROW,     // row address phase
      S_COL,     // column phase (read or write)
      S_PRE,     // precharge gap
      S_RCAS,    // refresh: column strobe lead
      S_RRAS     // refresh: both strobes low
   } seq_state_t;

   function automatic int unsigned max2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dramc_refresh_sched.sv
module dramc_refresh_sched #(
   parameter int unsigned REF_INTERVAL = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_ack,
   output logic ref_pend
);
   localparam int unsigned CNT_W = $clog2(REF_INTERVAL + 1);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(REF_INTERVAL - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             tick;

   assign tick = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= RELOAD;
         ref_pend <= 1'b0;
      end else begin
         cnt_q <= tick ? RELOAD : cnt_q - 1'b1;
         if (tick)
            ref_pend <= 1'b1;
         else if (ref_ack)
            ref_pend <= 1'b0;
      end
   end
endmodule

// File: rtl/dramc_addr_mux.sv
module dramc_addr_mux #(
   parameter int unsigned ROW_W = 11,
   parameter int unsigned COL_W = 10,
   parameter int unsigned PIN_W = 11
) (
   input  logic [ROW_W+COL_W-1:0] haddr,
   input  logic                   drive_row,
   input  logic                   drive_col,
   output logic [PIN_W-1:0]       pins
);
   logic [PIN_W-1:0] row_ext;
   logic [PIN_W-1:0] col_ext;

   generate
      if (ROW_W == PIN_W) begin : g_row_full
         assign row_ext = haddr[ROW_W+COL_W-1:COL_W];
      end else begin : g_row_pad
         assign row_ext = {{(PIN_W-ROW_W){1'b0}}, haddr[ROW_W+COL_W-1:COL_W]};
      end
      if (COL_W == PIN_W) begin : g_col_full
         assign col_ext = haddr[COL_W-1:0];
      end else begin : g_col_pad
         assign col_ext = {{(PIN_W-COL_W){1'b0}}, haddr[COL_W-1:0]};
      end
   endgenerate

   always_comb begin
      pins = '0;
      if (drive_row)
         pins = row_ext;
      else if (drive_col)
         pins = col_ext;
   end
endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
   import dramc_pkg::*;
#(
   parameter int unsigned HADDR_W     = 21,
   parameter int unsigned DQ_W        = 4,
   parameter int unsigned TMR_W       = 16,
   parameter int unsigned INIT_WAIT   = 20000,
   parameter int unsigned INIT_CYCLES = 8,
   parameter int unsigned T_RCD       = 2,
   parameter int unsigned D_COL       = 3,
   parameter int unsigned D_PRE       = 3,
   parameter int unsigned D_RAS       = 5,
   parameter int unsigned T_CSR       = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_pend,
   output logic               ref_ack,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [HADDR_W-1:0] req_addr,
   input  logic [DQ_W-1:0]    req_wdata,
   output logic               req_ready,
   output logic               rsp_valid,
   output logic [DQ_W-1:0]    rsp_rdata,
   input  logic [DQ_W-1:0]    dq_in,
   output logic [HADDR_W-1:0] addr_q,
   output logic               drive_row,
   output logic               drive_col,
   output logic               ras_n,
   output logic               cas_n,
   output logic               we_n,
   output logic               oe_n,
   output logic               dq_oe,
   output logic [DQ_W-1:0]    dq_out
);
   localparam int unsigned ICNT_W = $clog2(INIT_CYCLES + 1);
   localparam logic [TMR_W-1:0] L_WAIT = TMR_W'(INIT_WAIT - 1);
   localparam logic [TMR_W-1:0] L_RAS  = TMR_W'(D_RAS - 1);
   localparam logic [TMR_W-1:0] L_PRE  = TMR_W'(D_PRE - 1);
   localparam logic [TMR_W-1:0] L_RCD  = TMR_W'(T_RCD - 1);
   localparam logic [TMR_W-1:0] L_COL  = TMR_W'(D_COL - 1);
   localparam logic [TMR_W-1:0] L_CSR  = TMR_W'(T_CSR - 1);
   localparam logic [ICNT_W-1:0] ILAST = ICNT_W'(INIT_CYCLES - 1);

   seq_state_t        st_q, st_d;
   logic [TMR_W-1:0]  tmr_q, ld_val;
   logic [ICNT_W-1:0] icnt_q;
   logic              move, expired, accept, wr_q;

   assign expired = (tmr_q == '0);
   assign accept  = (st_q == S_IDLE) && !ref_pend && req_valid;
   assign ref_ack = (st_q == S_IDLE) && ref_pend;

   always_comb begin
      st_d   = st_q;
      ld_val = '0;
      unique case (st_q)
         S_WAIT: if (expired) begin st_d = S_IRAS; ld_val = L_RAS; end
         S_IRAS: if (expired) begin st_d = S_IPRE; ld_val = L_PRE; end
         S_IPRE: if (expired) begin
            if (icnt_q == ILAST) st_d = S_IDLE;
            else begin st_d = S_IRAS; ld_val = L_RAS; end
         end
         S_IDLE: begin
            if (ref_pend) begin st_d = S_RCAS; ld_val = L_CSR; end
            else if (req_valid) begin st_d = S_ROW; ld_val = L_RCD; end
         end
         S_ROW:  if (expired) begin st_d = S_COL;  ld_val = L_COL; end
         S_COL:  if (expired) begin st_d = S_PRE;  ld_val = L_PRE; end
         S_PRE:  if (expired) st_d = S_IDLE;
         S_RCAS: if (expired) begin st_d = S_RRAS; ld_val = L_RAS; end
         S_RRAS: if (expired) begin st_d = S_PRE;  ld_val = L_PRE; end
         default: st_d = S_IDLE;
      endcase
   end

   assign move = (st_d != st_q) || (st_q == S_IPRE && expired);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_WAIT;
         tmr_q  <= L_WAIT;
         icnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (move)
            tmr_q <= ld_val;
         else if (!expired)
            tmr_q <= tmr_q - 1'b1;
         if (st_q == S_IPRE && expired)
            icnt_q <= icnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q   <= 1'b0;
         addr_q <= '0;
         dq_out <= '0;
      end else if (accept) begin
         wr_q   <= req_write;
         addr_q <= req_addr;
         dq_out <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= (st_q == S_COL) && expired && !wr_q;
         if ((st_q == S_COL) && expired && !wr_q)
            rsp_rdata <= dq_in;
      end
   end

   assign req_ready = (st_q == S_IDLE) && !ref_pend;
   assign ras_n     = !(st_q inside {S_IRAS, S_ROW, S_COL, S_RRAS});
   assign cas_n     = !(st_q inside {S_COL, S_RCAS, S_RRAS});
   assign we_n      = !((st_q == S_COL) && wr_q);
   assign oe_n      = !((st_q == S_COL) && !wr_q);
   assign dq_oe     = wr_q && (st_q inside {S_ROW, S_COL});
   assign drive_row = (st_q == S_ROW);
   assign drive_col = (st_q == S_COL);
endmodule

// File: rtl/dramc_top.sv
module dramc_top
   import dramc_pkg::*;
#(
   parameter int unsigned ROW_W        = 11,
   parameter int unsigned COL_W        = 10,
   parameter int unsigned DQ_W         = 4,
   parameter int unsigned T_RCD        = 2,
   parameter int unsigned T_RAS        = 5,
   parameter int unsigned T_RAC        = 5,
   parameter int unsigned T_CAS        = 2,
   parameter int unsigned T_RP         = 3,
   parameter int unsigned T_CP         = 2,
   parameter int unsigned T_CSR        = 1,
   parameter int unsigned INIT_WAIT    = 20000,
   parameter int unsigned INIT_CYCLES  = 8,
   parameter int unsigned REF_INTERVAL = 1560
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic [ROW_W+COL_W-1:0]   req_addr,
   input  logic [DQ_W-1:0]          req_wdata,
   output logic                     rsp_valid,
   output logic [DQ_W-1:0]          rsp_rdata,
   output logic                     dram_ras_n,
   output logic                     dram_cas_n,
   output logic                     dram_we_n,
   output logic                     dram_oe_n,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
   output logic [DQ_W-1:0]          dram_dq_out,
   output logic                     dram_dq_oe,
   input  logic [DQ_W-1:0]          dram_dq_in
);
   localparam int unsigned HADDR_W = ROW_W + COL_W;
   localparam int unsigned PIN_W   = max2(ROW_W, COL_W);
   localparam int unsigned D_COL   = max2(T_CAS, max2(T_RAS - T_RCD, T_RAC - T_RCD));
   localparam int unsigned D_PRE   = max2(T_RP, T_CP);
   localparam int unsigned TMR_MAX = max2(max2(INIT_WAIT, D_COL), max2(max2(D_PRE, T_RAS), max2(T_RCD, T_CSR)));
   localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

   generate
      if (T_RAS <= T_RCD || T_RAC <= T_RCD) begin : g_bad_rcd
         $error("row-to-column delay must be shorter than row active and row access times");
      end
      if (T_RCD < 1 || T_CAS < 1 || T_RP < 1 || T_CP < 1 || T_CSR < 1) begin : g_bad_zero
         $error("every timing count must be at least one cycle");
      end
      if (INIT_WAIT < 1 || INIT_CYCLES < 1 || REF_INTERVAL < 2) begin : g_bad_init
         $error("init pause, dummy count and refresh interval must be nonzero");
      end
      if (REF_INTERVAL <= T_CSR + T_RAS + D_PRE + T_RCD + D_COL + D_PRE + 2) begin : g_bad_ref
         $error("refresh interval too short to fit one access and one refresh");
      end
   endgenerate

   logic               ref_pend, ref_ack, drive_row, drive_col;
   logic [HADDR_W-1:0] addr_q;

   dramc_refresh_sched #(.REF_INTERVAL(REF_INTERVAL)) u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_ack  (ref_ack),
      .ref_pend (ref_pend)
   );

   dramc_seq #(
      .HADDR_W     (HADDR_W),
      .DQ_W        (DQ_W),
      .TMR_W       (TMR_W),
      .INIT_WAIT   (INIT_WAIT),
      .INIT_CYCLES (INIT_CYCLES),
      .T_RCD       (T_RCD),
      .D_COL       (D_COL),
      .D_PRE       (D_PRE),
      .D_RAS       (T_RAS),
      .T_CSR       (T_CSR)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_pend  (ref_pend),
      .ref_ack   (ref_ack),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_ready (req_ready),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .dq_in     (dram_dq_in),
      .addr_q    (addr_q),
      .drive_row (drive_row),
      .drive_col (drive_col),
      .ras_n     (dram_ras_n),
      .cas_n     (dram_cas_n),
      .we_n      (dram_we_n),
      .oe_n      (dram_oe_n),
      .dq_oe     (dram_dq_oe),
      .dq_out    (dram_dq_out)
   );

   dramc_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_amux (
      .haddr     (addr_q),
      .drive_row (drive_row),
      .drive_col (drive_col),
      .pins      (dram_addr)
   );
endmodule

// File: rtl/dramc_check.sv
module dramc_check #(
   parameter int unsigned T_RAS       = 5,
   parameter int unsigned T_RP        = 3,
   parameter int unsigned T_CP        = 2,
   parameter int unsigned INIT_CYCLES = 8
) (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic rsp_valid,
   input logic dram_ras_n,
   input logic dram_cas_n,
   input logic dram_we_n,
   input logic dram_oe_n,
   input logic dram_dq_oe
);
   localparam int unsigned GAP = (T_RP > T_CP) ? T_RP : T_CP;

   logic [15:0] lo_cnt, hi_cnt, chi_cnt, init_falls;
   logic        ras_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt     <= '0;
         hi_cnt     <= '0;
         chi_cnt    <= '0;
         init_falls <= '0;
         ras_prev   <= 1'b1;
      end else begin
         ras_prev <= dram_ras_n;
         lo_cnt   <= dram_ras_n ? '0 : ((lo_cnt == 16'hffff) ? lo_cnt : lo_cnt + 1'b1);
         hi_cnt   <= !dram_ras_n ? '0 : ((hi_cnt == 16'hffff) ? hi_cnt : hi_cnt + 1'b1);
         chi_cnt  <= !dram_cas_n ? '0 : ((chi_cnt == 16'hffff) ? chi_cnt : chi_cnt + 1'b1);
         if (ras_prev && !dram_ras_n && dram_cas_n && init_falls != 16'hffff)
            init_falls <= init_falls + 1'b1;
      end
   end

   a_r4_min_ras_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_ras_n) |-> (lo_cnt >= 16'(T_RAS)));

   a_r5_ras_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (hi_cnt >= 16'(GAP)));

   a_r5_cas_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_cas_n) |-> (chi_cnt >= 16'(T_CP)));

   a_r8_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && dram_ras_n) |-> (dram_we_n && dram_oe_n && !dram_dq_oe));

   a_r7_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_we_n |-> (dram_dq_oe && !dram_cas_n && dram_oe_n));

   a_r6_read_we_high: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_oe_n |-> (dram_we_n && !dram_cas_n));

   a_r6_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($rose(dram_ras_n) && $past(!dram_oe_n)));

   a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (dram_ras_n && dram_cas_n));

   a_r2_init_done: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (init_falls >= 16'(INIT_CYCLES)));
endmodule

bind dramc_top dramc_check #(
   .T_RAS       (T_RAS),
   .T_RP        (T_RP),
   .T_CP        (T_CP),
   .INIT_CYCLES (INIT_CYCLES)
) u_check (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .dram_ras_n (dram_ras_n),
   .dram_cas_n (dram_cas_n),
   .dram_we_n  (dram_we_n),
   .dram_oe_n  (dram_oe_n),
   .dram_dq_oe (dram_dq_oe)
);

// File: tb/dramc_top_test.sv
module dramc_top_test;
   localparam int CLK_PERIOD   = 10;
   localparam int ROW_W        = 5;
   localparam int COL_W        = 4;
   localparam int DQ_W         = 4;
   localparam int PIN_W        = 5;
   localparam int HA_W         = ROW_W + COL_W;
   localparam int T_RCD        = 2;
   localparam int T_RAS        = 6;
   localparam int T_RP         = 3;
   localparam int T_CP         = 2;
   localparam int T_CSR        = 1;
   localparam int D_PRE        = 3;
   localparam int INIT_WAIT    = 50;
   localparam int INIT_CYCLES  = 8;
   localparam int REF_INTERVAL = 300;

   typedef struct packed {
      logic            wr;
      logic [HA_W-1:0] addr;
      logic [DQ_W-1:0] data;
   } vec_t;
   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 9'h000, 4'h5}, '{1'b1, 9'h1FF, 4'hA}, '{1'b1, 9'h0A5, 4'h3},
      '{1'b1, 9'h15A, 4'hC}, '{1'b0, 9'h000, 4'h5}, '{1'b0, 9'h1FF, 4'hA},
      '{1'b0, 9'h0A5, 4'h3}, '{1'b0, 9'h15A, 4'hC}, '{1'b1, 9'h0A5, 4'h6},
      '{1'b0, 9'h0A5, 4'h6}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [HA_W-1:0] req_addr = '0;
   logic [DQ_W-1:0] req_wdata = '0;
   logic req_ready, rsp_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
   logic [DQ_W-1:0] rsp_rdata, dram_dq_out, dram_dq_in;
   logic [PIN_W-1:0] dram_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   dramc_top #(
      .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
      .T_RAC(5), .T_CAS(2), .T_RP(T_RP), .T_CP(T_CP), .T_CSR(T_CSR),
      .INIT_WAIT(INIT_WAIT), .INIT_CYCLES(INIT_CYCLES), .REF_INTERVAL(REF_INTERVAL)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(dram_ras_n),
      .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
      .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
      .dram_dq_in(dram_dq_in)
   );

   int n_chk = 0, n_bad = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // memory model and pin monitor
   logic [DQ_W-1:0]  mem [1 << HA_W];
   logic [ROW_W-1:0] row_lat = '0;
   logic [COL_W-1:0] col_lat = '0;
   logic prev_ras = 1'b1, prev_cas = 1'b1, seen_ready = 1'b0;
   int lo_len = 0, hi_len = 0, clo_len = 0;
   int first_fall = -1, init_falls = 0, refreshes = 0;
   int min_lo = 1000, min_hi = 1000;
   int csr_err = 0, rcd_err = 0, colext_err = 0, wr_err = 0, ref_err = 0, busy_err = 0, rsp_err = 0;

   assign dram_dq_in = (!dram_oe_n && !dram_cas_n) ? mem[{row_lat, col_lat}] : '0;

   always @(negedge clk) if (rst_n) begin
      if (prev_ras && !dram_ras_n) begin
         if (!dram_cas_n) begin
            refreshes++;
            if (clo_len != T_CSR) csr_err++;
         end else begin
            row_lat = dram_addr[ROW_W-1:0];
            if (!seen_ready) init_falls++;
            if (first_fall < 0) first_fall = cyc;
         end
         if (hi_len < min_hi) min_hi = hi_len;
      end
      if (prev_cas && !dram_cas_n && !dram_ras_n) begin
         col_lat = dram_addr[COL_W-1:0];
         if (dram_addr[PIN_W-1:COL_W] != '0) colext_err++;
         if (lo_len != T_RCD) rcd_err++;
         if (!dram_we_n) begin
            if (!dram_dq_oe) wr_err++;
            mem[{row_lat, col_lat}] = dram_dq_out;
         end
      end
      if (!prev_ras && dram_ras_n && lo_len < min_lo) min_lo = lo_len;
      if (!dram_cas_n && dram_ras_n && (!dram_we_n || !dram_oe_n || dram_dq_oe)) ref_err++;
      if (req_ready && (!dram_ras_n || !dram_cas_n)) busy_err++;
      if (rsp_valid && !(dram_ras_n && !prev_ras)) rsp_err++;
      if (req_ready) seen_ready = 1'b1;
      lo_len  = dram_ras_n ? 0 : lo_len + 1;
      hi_len  = dram_ras_n ? hi_len + 1 : 0;
      clo_len = dram_cas_n ? 0 : clo_len + 1;
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
   end

   task automatic do_op(input bit wr, input logic [HA_W-1:0] a, input logic [DQ_W-1:0] d,
                        output logic [DQ_W-1:0] rd);
      int t;
      rd = '0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      t = 0;
      while (!req_ready && t < 2000) begin @(negedge clk); t++; end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (!wr) begin
         t = 0;
         while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
         rd = rsp_rdata;
      end else begin
         repeat (10) @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [DQ_W-1:0] rd;
      int t0, r0, t;
      for (int i = 0; i < (1 << HA_W); i++) mem[i] = '0;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(dram_ras_n && dram_cas_n, "R1 strobes", {dram_ras_n, dram_cas_n}, 3);
      chk(dram_we_n && dram_oe_n, "R1 we/oe", {dram_we_n, dram_oe_n}, 3);
      chk(!dram_dq_oe, "R1 dq_oe", dram_dq_oe, 0);
      chk(!req_ready && !rsp_valid, "R1 ready/rsp", {req_ready, rsp_valid}, 0);
      t0 = cyc;
      rst_n = 1'b1;
      t = 0;
      while (!req_ready && t < 5000) begin @(negedge clk); t++; end
      // R2 init
      chk(first_fall - t0 >= INIT_WAIT, "R2 pause", first_fall - t0, INIT_WAIT);
      chk(init_falls == INIT_CYCLES, "R2 dummy cycles", init_falls, INIT_CYCLES);
      chk(t >= INIT_WAIT + INIT_CYCLES * (T_RAS + D_PRE), "R2 ready hold", t,
          INIT_WAIT + INIT_CYCLES * (T_RAS + D_PRE));
      // table-driven accesses (R3 R6 R7)
      for (int i = 0; i < NV; i++) begin
         do_op(VEC[i].wr, VEC[i].addr, VEC[i].data, rd);
         if (VEC[i].wr) begin
            chk(row_lat == VEC[i].addr[HA_W-1:COL_W], "R3 row", row_lat, VEC[i].addr[HA_W-1:COL_W]);
            chk(col_lat == VEC[i].addr[COL_W-1:0], "R3 col", col_lat, VEC[i].addr[COL_W-1:0]);
            chk(mem[VEC[i].addr] == VEC[i].data, "R7 stored", mem[VEC[i].addr], VEC[i].data);
         end else begin
            chk(rd == VEC[i].data, "R6 read data", rd, VEC[i].data);
         end
      end
      chk(colext_err == 0, "R3 column zero-extend", colext_err, 0);
      chk(wr_err == 0, "R7 data drive", wr_err, 0);
      chk(rsp_err == 0, "R6 rsp timing", rsp_err, 0);
      chk(rcd_err == 0, "R4 ras-to-cas", rcd_err, 0);
      chk(min_lo >= T_RAS, "R4 ras low", min_lo, T_RAS);
      chk(min_hi >= D_PRE, "R5 precharge", min_hi, D_PRE);
      // R9 idle refresh rate
      r0 = refreshes;
      repeat (3 * REF_INTERVAL) @(negedge clk);
      chk(refreshes - r0 >= 2 && refreshes - r0 <= 4, "R9 refresh count", refreshes - r0, 3);
      chk(csr_err == 0, "R8 cas lead", csr_err, 0);
      chk(ref_err == 0, "R8 refresh quiet", ref_err, 0);
      // R10 continuous traffic with refresh preemption
      r0 = refreshes;
      for (int i = 0; i < 40; i++) do_op(1'b1, HA_W'(i * 13 + 7), DQ_W'(i ^ 9), rd);
      for (int i = 0; i < 40; i++) begin
         do_op(1'b0, HA_W'(i * 13 + 7), '0, rd);
         chk(rd == DQ_W'(i ^ 9), "R10 data under refresh", rd, DQ_W'(i ^ 9));
      end
      chk(refreshes - r0 >= 2, "R10 refreshes interleaved", refreshes - r0, 2);
      chk(busy_err == 0, "R10 ready only idle", busy_err, 0);
      chk(min_lo >= T_RAS, "R4 ras low after traffic", min_lo, T_RAS);
      chk(min_hi >= D_PRE, "R5 precharge after traffic", min_hi, D_PRE);
      chk(ref_err == 0 && csr_err == 0, "R8 refresh under traffic", ref_err + csr_err, 0);
      // R1 reset again mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(dram_ras_n && dram_cas_n && !req_ready && !dram_dq_oe, "R1 re-reset",
          {dram_ras_n, dram_cas_n, req_ready, dram_dq_oe}, 12);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule